// File: doc/BRIEF.md
# Banked Memory Window Address Remapper

This block sits between the bus masters of a machine with 24-bit addressing and its memory decoders. It turns every CPU or DMA byte address into a physical address and a region tag. Two 128 KB apertures in conventional memory, at 0x80000 and 0xA0000, can each be moved by a window register. The window register supplies address bits 23:17 and the low 17 address bits pass through unchanged. Any translated address at or above a fixed upper-memory limit folds back into the first megabyte.

For DMA accesses, a control register can clip the address to 20 bits before translation. A small I/O register port reads and writes the control and window registers and reports the installed RAM size. Each translation is registered: the result appears one cycle after the access strobe.

Top module: `mem_window_remap`

## Requirements
- R1: After reset, the control register reads 0xFE, the low-aperture window reads 0x08 and the high-aperture window reads 0x0A, so both apertures map to themselves.
- R2: A write to a window port (port 1 for the aperture at 0x80000, port 2 for the aperture at 0xA0000) keeps bits 7:1 of the data byte as physical bits 23:17. A read of that port returns the kept bits with bit 0 clear.
- R3: An address from 0x80000 to 0x9FFFF translates to its low 17 bits ORed with the low-aperture window.
- R4: An address from 0xA0000 to 0xBFFFF translates to its low 17 bits ORed with the high-aperture window.
- R5: An address below 0x80000, or from 0xC0000 up to just below the upper limit 0xFA0000, passes through unchanged.
- R6: A translated address at or above 0xFA0000 is reduced to its low 20 bits and tagged as wrapped.
- R7: When control bit 2 is set, a DMA address is masked to 20 bits before translation. When bit 2 is clear, the full DMA address is used. CPU accesses are never masked.
- R8: The control register (port 0) accepts and returns a full 8-bit value.
- R9: The size port (port 3) returns the RAM size in 128 KB units (0x20 by default), and writes to it have no effect.
- R10: A read from ports 4 to 7 returns 0xFF. A write to them leaves all registers unchanged.
- R11: The region tag is 2 for wrapped, 1 when the final address lies in 0xA0000..0xBFFFF, and 0 otherwise.
- R12: The output valid flag, write flag, address and tag appear one cycle after the access strobe. A register write in the same cycle as an access affects only later accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe |
| acc_we | input | 1 | Access is a write |
| acc_dma | input | 1 | Access comes from DMA |
| acc_addr | input | 24 | Byte address from the bus master |
| io_we | input | 1 | Register port write strobe |
| io_addr | input | 3 | Register port select |
| io_wdata | input | 8 | Register port write data |
| io_rdata | output | 8 | Register port read data (combinational) |
| out_valid | output | 1 | Translated access valid |
| out_we | output | 1 | Translated access is a write |
| out_addr | output | 24 | Physical address |
| out_region | output | 2 | Region tag |

## Verification
A window register write and an aperture access can fall in the same clock cycle. The bench provokes this by raising both strobes on one edge. It then checks that this access still uses the old window, and that the access on the next cycle uses the new one. A second interaction happens when a relocated window lands above the upper limit. In that case the aperture translation and the wrap are applied to the same access, and the bench checks both the folded address and the wrapped tag.

// File: rtl/remap_pkg.sv
package remap_pkg;

    localparam int PA_W = 24;

    typedef enum logic [1:0] {
        REG_RAM  = 2'd0,
        REG_DISP = 2'd1,
        REG_WRAP = 2'd2
    } region_e;

    typedef struct packed {
        logic [PA_W-1:0] addr;
        region_e         region;
    } xlate_t;

    // aperture selectors work on bits 23:17 (128 KB granules)
    function automatic logic in_lo_aperture(input logic [PA_W-1:0] a);
        return a[PA_W-1:17] == 7'h04;
    endfunction

    function automatic logic in_hi_aperture(input logic [PA_W-1:0] a);
        return a[PA_W-1:17] == 7'h05;
    endfunction

endpackage

// File: rtl/remap_regs.sv
module remap_regs #(
    parameter int          IO_AW      = 3,
    parameter int          PORT_CTRL  = 0,
    parameter int          PORT_WLO   = 1,
    parameter int          PORT_WHI   = 2,
    parameter int          PORT_SIZE  = 3,
    parameter logic [31:0] RAM_BYTES  = 32'h0040_0000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             io_we,
    input  logic [IO_AW-1:0] io_addr,
    input  logic [7:0]       io_wdata,
    output logic [7:0]       io_rdata,
    output logic [6:0]       win_lo,
    output logic [6:0]       win_hi,
    output logic             dma_clip
);
    localparam logic [7:0] SIZE_UNITS = RAM_BYTES[24:17];
    localparam logic [7:0] CTRL_RST   = 8'hFE;
    localparam logic [6:0] WLO_RST    = 7'h04;
    localparam logic [6:0] WHI_RST    = 7'h05;

    logic [7:0] ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RST;
            win_lo <= WLO_RST;
            win_hi <= WHI_RST;
        end else if (io_we) begin
            if (io_addr == IO_AW'(PORT_CTRL)) ctrl_q <= io_wdata;
            if (io_addr == IO_AW'(PORT_WLO))  win_lo <= io_wdata[7:1];
            if (io_addr == IO_AW'(PORT_WHI))  win_hi <= io_wdata[7:1];
        end
    end

    always_comb begin
        if (io_addr == IO_AW'(PORT_CTRL))      io_rdata = ctrl_q;
        else if (io_addr == IO_AW'(PORT_WLO))  io_rdata = {win_lo, 1'b0};
        else if (io_addr == IO_AW'(PORT_WHI))  io_rdata = {win_hi, 1'b0};
        else if (io_addr == IO_AW'(PORT_SIZE)) io_rdata = SIZE_UNITS;
        else                                   io_rdata = 8'hFF;
    end

    assign dma_clip = ctrl_q[2];

    // R1: reset values
    p_reset_vals_r1: assert property (@(posedge clk)
        rst |=> (ctrl_q == 8'hFE && win_lo == 7'h04 && win_hi == 7'h05));

    // R2: a window write keeps the upper seven data bits
    p_wlo_write_r2: assert property (@(posedge clk) disable iff (rst)
        (io_we && io_addr == IO_AW'(PORT_WLO)) |=> (win_lo == $past(io_wdata[7:1])));

    // R10: writes to unmapped ports leave all registers unchanged
    p_unknown_write_r10: assert property (@(posedge clk) disable iff (rst)
        (io_we && io_addr > IO_AW'(PORT_SIZE)) |=>
        ($stable(ctrl_q) && $stable(win_lo) && $stable(win_hi)));
endmodule

// File: rtl/remap_xlate.sv
module remap_xlate
    import remap_pkg::*;
#(
    parameter logic [PA_W-1:0] UPPER_LIMIT = 24'hFA0000
) (
    input  logic [PA_W-1:0] addr_in,
    input  logic            is_dma,
    input  logic            dma_clip,
    input  logic [6:0]      win_lo,
    input  logic [6:0]      win_hi,
    output xlate_t          result
);
    localparam logic [PA_W-1:0] LOW_MB_MASK = 24'h0F_FFFF;
    localparam logic [PA_W-1:0] DISP_LO     = 24'h0A_0000;
    localparam logic [PA_W-1:0] DISP_HI     = 24'h0B_FFFF;

    logic [PA_W-1:0] pre;
    logic [PA_W-1:0] mapped;

    always_comb begin
        pre = (is_dma && dma_clip) ? (addr_in & LOW_MB_MASK) : addr_in;

        if (in_lo_aperture(pre))      mapped = {win_lo, pre[16:0]};
        else if (in_hi_aperture(pre)) mapped = {win_hi, pre[16:0]};
        else                          mapped = pre;

        if (mapped >= UPPER_LIMIT) begin
            result.addr   = mapped & LOW_MB_MASK;
            result.region = REG_WRAP;
        end else begin
            result.addr   = mapped;
            result.region = (mapped >= DISP_LO && mapped <= DISP_HI) ? REG_DISP : REG_RAM;
        end
    end
endmodule

// File: rtl/mem_window_remap.sv
module mem_window_remap
    import remap_pkg::*;
#(
    parameter int          IO_AW       = 3,
    parameter int          PORT_CTRL   = 0,
    parameter int          PORT_WLO    = 1,
    parameter int          PORT_WHI    = 2,
    parameter int          PORT_SIZE   = 3,
    parameter logic [31:0] RAM_BYTES   = 32'h0040_0000,
    parameter logic [23:0] UPPER_LIMIT = 24'hFA0000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_valid,
    input  logic             acc_we,
    input  logic             acc_dma,
    input  logic [23:0]      acc_addr,
    input  logic             io_we,
    input  logic [IO_AW-1:0] io_addr,
    input  logic [7:0]       io_wdata,
    output logic [7:0]       io_rdata,
    output logic             out_valid,
    output logic             out_we,
    output logic [23:0]      out_addr,
    output logic [1:0]       out_region
);
    logic [6:0] win_lo, win_hi;
    logic       dma_clip;
    xlate_t     xl;

    remap_regs #(
        .IO_AW(IO_AW), .PORT_CTRL(PORT_CTRL), .PORT_WLO(PORT_WLO),
        .PORT_WHI(PORT_WHI), .PORT_SIZE(PORT_SIZE), .RAM_BYTES(RAM_BYTES)
    ) u_regs (
        .clk(clk), .rst(rst), .io_we(io_we), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata),
        .win_lo(win_lo), .win_hi(win_hi), .dma_clip(dma_clip)
    );

    remap_xlate #(.UPPER_LIMIT(UPPER_LIMIT)) u_xlate (
        .addr_in(acc_addr), .is_dma(acc_dma), .dma_clip(dma_clip),
        .win_lo(win_lo), .win_hi(win_hi), .result(xl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_we     <= 1'b0;
            out_addr   <= '0;
            out_region <= REG_RAM;
        end else begin
            out_valid <= acc_valid;
            if (acc_valid) begin
                out_we     <= acc_we;
                out_addr   <= xl.addr;
                out_region <= xl.region;
            end
        end
    end

    // R5: low conventional memory bypasses translation
    p_low_pass_r5: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_dma && acc_addr < 24'h08_0000) |=> (out_addr == $past(acc_addr)));

    // R3: aperture offsets survive relocation
    p_aperture_offset_r3: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_dma && acc_addr[23:17] == 7'h04) |=>
        (out_addr[16:0] == $past(acc_addr[16:0])));

    // R6: wrapped results stay inside the first megabyte
    p_wrap_low_mb_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_region == 2'd2) |-> (out_addr[23:20] == 4'h0));

    // R12: the output strobe follows the access strobe by one cycle
    p_latency_r12: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> out_valid);
endmodule

// File: tb/mem_window_remap_tb.sv
`timescale 1ns/1ps
module mem_window_remap_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0, acc_we = 1'b0, acc_dma = 1'b0;
    logic [23:0] acc_addr = '0;
    logic        io_we = 1'b0;
    logic [2:0]  io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        out_valid, out_we;
    logic [23:0] out_addr;
    logic [1:0]  out_region;

    int checks = 0, fails = 0, cycles = 0;

    always #2.5 clk = ~clk;

    mem_window_remap u_dut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_we(acc_we),
        .acc_dma(acc_dma), .acc_addr(acc_addr), .io_we(io_we),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .out_valid(out_valid), .out_we(out_we), .out_addr(out_addr),
        .out_region(out_region)
    );

    // {dma, address, expected address, expected tag}; reset windows, control 0xFE
    localparam int NV = 12;
    localparam logic [50:0] VECS [NV] = '{
        {1'b0, 24'h012345, 24'h012345, 2'd0},
        {1'b0, 24'h085678, 24'h085678, 2'd0},
        {1'b0, 24'h0A1234, 24'h0A1234, 2'd1},
        {1'b0, 24'h0BFFFF, 24'h0BFFFF, 2'd1},
        {1'b0, 24'h0C0000, 24'h0C0000, 2'd0},
        {1'b0, 24'h0FFFFF, 24'h0FFFFF, 2'd0},
        {1'b0, 24'h5A0000, 24'h5A0000, 2'd0},
        {1'b0, 24'hF9FFFF, 24'hF9FFFF, 2'd0},
        {1'b0, 24'hFA0000, 24'h0A0000, 2'd2},
        {1'b0, 24'hFFFFFF, 24'h0FFFFF, 2'd2},
        {1'b1, 24'h312345, 24'h012345, 2'd0},
        {1'b1, 24'hF8A000, 24'h08A000, 2'd0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    task automatic access(input logic dma, input logic we, input logic [23:0] a,
                          input logic [23:0] ea, input logic [1:0] er, input string req);
        @(negedge clk);
        acc_valid = 1'b1; acc_we = we; acc_dma = dma; acc_addr = a;
        @(negedge clk);
        acc_valid = 1'b0; acc_we = 1'b0; acc_dma = 1'b0;
        chk({req, " addr"}, 32'(out_addr), 32'(ea));
        chk({req, " tag"}, 32'(out_region), 32'(er));
        chk({req, " valid/we"}, {out_valid, out_we}, {1'b1, we});
    endtask

    task automatic io_write(input logic [2:0] p, input logic [7:0] d);
        @(negedge clk);
        io_we = 1'b1; io_addr = p; io_wdata = d;
        @(negedge clk);
        io_we = 1'b0;
    endtask

    task automatic io_read(input logic [2:0] p, input logic [7:0] e, input string req);
        @(negedge clk);
        io_addr = p;
        #1;
        chk(req, 32'(io_rdata), 32'(e));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R12 reset out_valid", 32'(out_valid), 0);
        io_read(3'd0, 8'hFE, "R1 ctrl reset");
        io_read(3'd1, 8'h08, "R1 low window reset");
        io_read(3'd2, 8'h0A, "R1 high window reset");

        // R3 R4 R5 R6 R7 R11 table at reset mapping
        for (int i = 0; i < NV; i++) begin
            logic [50:0] v;
            v = VECS[i];
            access(v[50], 1'(i % 2), v[49:26], v[25:2], v[1:0], $sformatf("R5/R6/R11 vec%0d", i));
        end

        // R2 odd data loses bit 0; R3 relocation
        io_write(3'd1, 8'h31);
        io_read(3'd1, 8'h30, "R2 low window readback");
        access(1'b0, 1'b0, 24'h081234, 24'h301234, 2'd0, "R3 relocated low");
        // R4 relocation landing above the limit folds and wraps (R6)
        io_write(3'd2, 8'hFB);
        io_read(3'd2, 8'hFA, "R2 high window readback");
        access(1'b0, 1'b1, 24'h0A0010, 24'h0A0010, 2'd2, "R4 R6 window above limit");
        io_write(3'd2, 8'h41);
        access(1'b0, 1'b0, 24'h0B0005, 24'h410005, 2'd0, "R4 relocated high");
        // R11 low aperture pointed at display space
        io_write(3'd1, 8'h0A);
        access(1'b0, 1'b0, 24'h080004, 24'h0A0004, 2'd1, "R11 display via window");

        // R8 R7 control register
        io_write(3'd0, 8'h00);
        io_read(3'd0, 8'h00, "R8 ctrl readback zero");
        access(1'b1, 1'b0, 24'h312345, 24'h312345, 2'd0, "R7 dma unmasked");
        io_write(3'd0, 8'hA5);
        io_read(3'd0, 8'hA5, "R8 ctrl readback A5");
        access(1'b1, 1'b0, 24'h712345, 24'h012345, 2'd0, "R7 dma masked");
        access(1'b0, 1'b0, 24'h712345, 24'h712345, 2'd0, "R7 cpu never masked");

        // R9 size port
        io_read(3'd3, 8'h20, "R9 size");
        io_write(3'd3, 8'h55);
        io_read(3'd3, 8'h20, "R9 size after write");

        // R10 unmapped ports
        io_read(3'd5, 8'hFF, "R10 unknown read");
        io_write(3'd5, 8'h00);
        io_write(3'd7, 8'h00);
        io_read(3'd0, 8'hA5, "R10 ctrl unchanged");
        io_read(3'd1, 8'h0A, "R10 low window unchanged");
        io_read(3'd2, 8'h40, "R10 high window unchanged");

        // R12 register write and access on the same edge
        @(negedge clk);
        io_we = 1'b1; io_addr = 3'd1; io_wdata = 8'h20;
        acc_valid = 1'b1; acc_we = 1'b0; acc_dma = 1'b0; acc_addr = 24'h080010;
        @(negedge clk);
        io_we = 1'b0; acc_valid = 1'b0;
        chk("R12 same-cycle uses old window", 32'(out_addr), 32'h0A0010);
        chk("R12 same-cycle tag", 32'(out_region), 32'd1);
        access(1'b0, 1'b0, 24'h080010, 24'h200010, 2'd0, "R12 next access uses new window");

        @(negedge clk);
        chk("R12 valid drops", 32'(out_valid), 0);
        finish_run();
    end
endmodule